// File: doc/BRIEF.md
# Memoizing Product Reuse Unit

This block sits in front of an integer multiplier inside a matrix-vector datapath. An input activation is loaded and held. Quantized weight codes then stream in, one per cycle, under a valid/ready handshake. For each code the block returns the signed product of the code and the held activation, also under a valid/ready handshake. Results always leave in the order the codes were accepted.

A small fully associative cache, keyed by weight code, remembers products already formed with the current activation. A repeated code is answered from the cache through a reuse path without a multiply. A new code is sent through a three-stage multiplier, and its result is written into the cache when it completes. A code that repeats while its first multiply is still in flight joins that multiply and starts no second one. A short result queue puts early cache answers back into order behind outstanding multiplies.

Each entry keeps a saturating use count and a recency stamp, both built up at run time from the incoming stream. Replacement evicts the least-used entry and, among equals, the one touched longest ago. Loading a new activation invalidates every entry at once. Running hit and miss totals are brought out so that the reuse rate can be compared against a model.

Top module: `prod_reuse_unit`

## Requirements
- R1: Every result equals the product of the accepted weight code and the activation held when that code was accepted, both read as two's complement, truncated to CODE_W+ACT_W bits.
- R2: Results leave in exactly the order their codes were accepted, one result per accepted code.
- R3: A code that matches a valid entry whose product is already stored counts as a hit. When no older result is waiting and r_ready is high, its result is offered in the cycle after the accepting clock edge.
- R4: A code with no matching entry counts as a miss and starts one multiply. With nothing older waiting, its result is offered after the third clock edge following the accepting edge.
- R5: A code that matches an entry whose multiply is still in flight counts as a miss, starts no multiply and takes the in-flight result. An entry's stored product becomes usable to codes accepted four or more edges after the edge that allocated it.
- R6: A high act_load stores act_in, holds w_ready low in that cycle and invalidates every entry. Multiplies still in flight finish with the old activation but do not refill the cache. The recency clock restarts at zero.
- R7: A miss fills the lowest-index invalid entry. If there is none, it evicts the entry with the smallest use count among those with no multiply in flight, and among equal counts the one with the oldest stamp. An entry's use count is set to 1 on fill, rises by one per match and saturates at 15. Its stamp is the number of codes accepted since the last load, taken at its latest fill or match.
- R8: hit_count and miss_count each rise by one for every accepted code that is a hit or a miss respectively, so their sum grows by exactly the number of accepted codes.
- R9: w_ready is low while QDEPTH results are held. An offered result keeps r_valid high and r_prod unchanged until r_ready takes it.
- R10: After reset and the two-cycle synchronous release, r_valid is low, w_ready is high and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside through two flops |
| act_load | input | 1 | Load act_in as the new activation and invalidate the cache |
| act_in | input | ACT_W | Activation value, two's complement |
| w_valid | input | 1 | Weight code offered |
| w_ready | output | 1 | Weight code can be taken this cycle |
| w_code | input | CODE_W | Quantized weight code, two's complement |
| r_valid | output | 1 | Product offered |
| r_ready | input | 1 | Product taken this cycle |
| r_prod | output | CODE_W+ACT_W | Product of code and activation |
| hit_count | output | CNT_W | Running count of hits |
| miss_count | output | CNT_W | Running count of misses |

## Verification
The bench numbers clock edges and samples every port just before the next edge. It therefore sees a counter change or a cache fill one sample after the edge that caused it. With nothing queued ahead and r_ready held, it expects a hit's product one sample after the accepting edge and a fresh miss's product four samples after. Each product is compared against a queue of expected values in acceptance order. A reference model of the cache keeps, for every entry, the edge from which its product is usable. That lets it separate true hits from in-flight joins and predict evictions, and the hit and miss counters are compared against it at every sample.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned FREQ_W   = 4;
  localparam logic [FREQ_W-1:0] FREQ_MAX = 4'd15;
  localparam int unsigned MUL_LAT  = 3;
endpackage

// File: rtl/prc_mul_pipe.sv
module prc_mul_pipe #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ACT_W  = 8,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LAT    = 3,
  localparam int unsigned PROD_W = CODE_W + ACT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [CODE_W-1:0] code,
  input  logic [ACT_W-1:0]  act,
  input  logic [TAG_W-1:0]  tag,
  input  logic [IDX_W-1:0]  idx,
  input  logic              kill_all,
  output logic              wb_valid,
  output logic              wb_kill,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [PROD_W-1:0] wb_prod
);
  logic signed [PROD_W-1:0] c_ext, a_ext;
  assign c_ext = PROD_W'(signed'(code));
  assign a_ext = PROD_W'(signed'(act));

  for (genvar k = 0; k < LAT; k++) begin : g_st
    logic              v, kl, v_n, kl_n;
    logic [TAG_W-1:0]  tg, tg_n;
    logic [IDX_W-1:0]  ix, ix_n;
    logic [PROD_W-1:0] pr, pr_n;
    if (k == 0) begin : g_in
      assign v_n  = issue;
      assign kl_n = 1'b0;
      assign tg_n = tag;
      assign ix_n = idx;
      assign pr_n = c_ext * a_ext;
    end else begin : g_mid
      assign v_n  = g_st[k-1].v;
      assign kl_n = g_st[k-1].kl | kill_all;
      assign tg_n = g_st[k-1].tg;
      assign ix_n = g_st[k-1].ix;
      assign pr_n = g_st[k-1].pr;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v  <= 1'b0;
        kl <= 1'b0;
      end else begin
        v  <= v_n;
        kl <= kl_n;
      end
    end
    always_ff @(posedge clk) begin
      if (v_n) begin
        tg <= tg_n;
        ix <= ix_n;
        pr <= pr_n;
      end
    end
  end

  assign wb_valid = g_st[LAT-1].v;
  assign wb_kill  = g_st[LAT-1].kl;
  assign wb_tag   = g_st[LAT-1].tg;
  assign wb_idx   = g_st[LAT-1].ix;
  assign wb_prod  = g_st[LAT-1].pr;
endmodule

// File: rtl/prc_victim_sel.sv
module prc_victim_sel
  import prc_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned STAMP_W = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] pend,
  input  logic [FREQ_W-1:0]  freq  [ENTRIES],
  input  logic [STAMP_W-1:0] stamp [ENTRIES],
  output logic [IDX_W-1:0]   vidx
);
  always_comb begin
    logic have_inv, have_cand;
    logic [IDX_W-1:0]   inv_idx, cand_idx;
    logic [FREQ_W-1:0]  best_f;
    logic [STAMP_W-1:0] best_s;
    have_inv  = 1'b0;
    have_cand = 1'b0;
    inv_idx   = '0;
    cand_idx  = '0;
    best_f    = '0;
    best_s    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i]) begin
        if (!have_inv) begin
          have_inv = 1'b1;
          inv_idx  = IDX_W'(i);
        end
      end else if (!pend[i]) begin
        if (!have_cand || freq[i] < best_f ||
            (freq[i] == best_f && stamp[i] < best_s)) begin
          have_cand = 1'b1;
          cand_idx  = IDX_W'(i);
          best_f    = freq[i];
          best_s    = stamp[i];
        end
      end
    end
    vidx = have_inv ? inv_idx : cand_idx;
  end
endmodule

// File: rtl/prc_result_q.sv
module prc_result_q #(
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned TAG_W = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_rdy,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [DATA_W-1:0] push_data,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              pop,
  output logic              full,
  output logic [TAG_W-1:0]  tail,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned CNT_W = $clog2(QDEPTH + 1);

  logic [QDEPTH-1:0] rdy, n_rdy;
  logic [TAG_W-1:0]  wtag [QDEPTH];
  logic [TAG_W-1:0]  n_wtag [QDEPTH];
  logic [DATA_W-1:0] data [QDEPTH];
  logic [DATA_W-1:0] n_data [QDEPTH];
  logic [TAG_W-1:0]  head, n_head, n_tail;
  logic [CNT_W-1:0]  cnt, n_cnt;

  always_comb begin
    n_rdy  = rdy;
    n_wtag = wtag;
    n_data = data;
    if (wb_valid) begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (!rdy[i] && wtag[i] == wb_tag) begin
          n_rdy[i]  = 1'b1;
          n_data[i] = wb_data;
        end
      end
    end
    if (push) begin
      n_rdy[tail]  = push_rdy;
      n_wtag[tail] = push_tag;
      n_data[tail] = push_data;
    end
    n_head = pop  ? head + 1'b1 : head;
    n_tail = push ? tail + 1'b1 : tail;
    n_cnt  = cnt + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= n_head;
      tail <= n_tail;
      cnt  <= n_cnt;
    end
  end

  always_ff @(posedge clk) begin
    rdy  <= n_rdy;
    wtag <= n_wtag;
    data <= n_data;
  end

  assign full      = (cnt == CNT_W'(QDEPTH));
  assign out_valid = (cnt != '0) && rdy[head];
  assign out_data  = data[head];
endmodule

// File: rtl/prod_reuse_unit.sv
module prod_reuse_unit
  import prc_pkg::*;
#(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned ACT_W   = 8,
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned QDEPTH  = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned STAMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_load,
  input  logic [ACT_W-1:0]        act_in,
  input  logic                    w_valid,
  output logic                    w_ready,
  input  logic [CODE_W-1:0]       w_code,
  output logic                    r_valid,
  input  logic                    r_ready,
  output logic [CODE_W+ACT_W-1:0] r_prod,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);
  localparam int unsigned PROD_W = CODE_W + ACT_W;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned TAG_W  = $clog2(QDEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sh;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_core_n = rst_sh[1];

  logic [ACT_W-1:0] act_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   act_q <= '0;
    else if (act_load) act_q <= act_in;
  end

  // cache entry state
  logic [ENTRIES-1:0] e_valid, e_pend, n_valid, n_pend;
  logic [CODE_W-1:0]  e_code  [ENTRIES];
  logic [CODE_W-1:0]  n_code  [ENTRIES];
  logic [FREQ_W-1:0]  e_freq  [ENTRIES];
  logic [FREQ_W-1:0]  n_freq  [ENTRIES];
  logic [STAMP_W-1:0] e_stamp [ENTRIES];
  logic [STAMP_W-1:0] n_stamp [ENTRIES];
  logic [TAG_W-1:0]   e_tag   [ENTRIES];
  logic [TAG_W-1:0]   n_tag   [ENTRIES];
  logic [PROD_W-1:0]  e_prod  [ENTRIES];
  logic [PROD_W-1:0]  n_prod  [ENTRIES];
  logic [STAMP_W-1:0] use_q, n_use;
  logic [CNT_W-1:0]   hit_q, miss_q, n_hit, n_miss;

  logic               found, accept, hit, merge, alloc, touch, wb_live;
  logic [IDX_W-1:0]   f_idx, v_idx;
  logic               q_full, push_rdy;
  logic [TAG_W-1:0]   q_tail, push_tag;
  logic [PROD_W-1:0]  push_data;
  logic               wb_valid, wb_kill;
  logic [TAG_W-1:0]   wb_tag;
  logic [IDX_W-1:0]   wb_idx;
  logic [PROD_W-1:0]  wb_prod;

  always_comb begin
    found = 1'b0;
    f_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && e_valid[i] && e_code[i] == w_code) begin
        found = 1'b1;
        f_idx = IDX_W'(i);
      end
    end
  end

  assign w_ready = rst_core_n & ~q_full & ~act_load;
  assign accept  = w_valid & w_ready;
  assign hit     = accept & found & ~e_pend[f_idx];
  assign merge   = accept & found & e_pend[f_idx];
  assign touch   = hit | merge;
  assign alloc   = accept & ~found;
  assign wb_live = wb_valid & ~wb_kill;

  prc_victim_sel #(.ENTRIES(ENTRIES), .STAMP_W(STAMP_W)) u_vsel (
    .valid(e_valid), .pend(e_pend), .freq(e_freq), .stamp(e_stamp), .vidx(v_idx)
  );

  prc_mul_pipe #(.CODE_W(CODE_W), .ACT_W(ACT_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
                 .LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst_n(rst_core_n), .issue(alloc), .code(w_code), .act(act_q),
    .tag(q_tail), .idx(v_idx), .kill_all(act_load),
    .wb_valid(wb_valid), .wb_kill(wb_kill), .wb_tag(wb_tag), .wb_idx(wb_idx),
    .wb_prod(wb_prod)
  );

  // a joining miss may complete in the very cycle it is accepted
  assign push_tag  = merge ? e_tag[f_idx] : q_tail;
  assign push_rdy  = hit | (merge & wb_valid & (wb_tag == e_tag[f_idx]));
  assign push_data = hit ? e_prod[f_idx] : wb_prod;

  prc_result_q #(.QDEPTH(QDEPTH), .DATA_W(PROD_W)) u_rq (
    .clk(clk), .rst_n(rst_core_n), .push(accept), .push_rdy(push_rdy),
    .push_tag(push_tag), .push_data(push_data), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_prod), .pop(r_valid & r_ready),
    .full(q_full), .tail(q_tail), .out_valid(r_valid), .out_data(r_prod)
  );

  always_comb begin
    n_valid = e_valid;
    n_pend  = e_pend;
    n_code  = e_code;
    n_freq  = e_freq;
    n_stamp = e_stamp;
    n_tag   = e_tag;
    n_prod  = e_prod;
    if (act_load) begin
      n_valid = '0;
      n_pend  = '0;
    end else begin
      if (wb_live) begin
        n_pend[wb_idx] = 1'b0;
        n_prod[wb_idx] = wb_prod;
      end
      if (touch) begin
        if (e_freq[f_idx] != FREQ_MAX) n_freq[f_idx] = e_freq[f_idx] + 1'b1;
        n_stamp[f_idx] = use_q;
      end
      if (alloc) begin
        n_valid[v_idx] = 1'b1;
        n_pend[v_idx]  = 1'b1;
        n_code[v_idx]  = w_code;
        n_freq[v_idx]  = FREQ_W'(1);
        n_stamp[v_idx] = use_q;
        n_tag[v_idx]   = q_tail;
      end
    end
    if (act_load)                    n_use = '0;
    else if (accept && ~&use_q)      n_use = use_q + 1'b1;
    else                             n_use = use_q;
    n_hit  = hit_q  + CNT_W'(hit);
    n_miss = miss_q + CNT_W'(alloc | merge);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      e_valid <= '0;
      e_pend  <= '0;
      use_q   <= '0;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      e_valid <= n_valid;
      e_pend  <= n_pend;
      use_q   <= n_use;
      hit_q   <= n_hit;
      miss_q  <= n_miss;
    end
  end

  always_ff @(posedge clk) begin
    e_code  <= n_code;
    e_freq  <= n_freq;
    e_stamp <= n_stamp;
    e_tag   <= n_tag;
    e_prod  <= n_prod;
  end

  assign hit_count  = hit_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/prc_reuse_chk.sv
module prc_reuse_chk #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned PROD_W  = 16,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               act_load,
  input logic               w_valid,
  input logic               w_ready,
  input logic               r_valid,
  input logic               r_ready,
  input logic [PROD_W-1:0]  r_prod,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count,
  input logic               q_full,
  input logic [ENTRIES-1:0] e_valid,
  input logic [ENTRIES-1:0] e_pend,
  input logic               alloc,
  input logic [IDX_W-1:0]   v_idx
);
  logic [CNT_W-1:0] tot;
  logic             acc;
  assign tot = hit_count + miss_count;
  assign acc = w_valid & w_ready;

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready |=> r_valid && $stable(r_prod));

  // R9
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !w_ready);

  // R6
  load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_load |-> !w_ready);

  // R6
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_load |=> e_valid == '0);

  // R8
  count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tot == $past(tot) + CNT_W'($past(acc)));

  // R7
  no_pending_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !e_pend[v_idx]);
endmodule

bind prod_reuse_unit prc_reuse_chk #(
  .ENTRIES(ENTRIES), .IDX_W($clog2(ENTRIES)), .PROD_W(CODE_W + ACT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_core_n), .act_load(act_load), .w_valid(w_valid),
  .w_ready(w_ready), .r_valid(r_valid), .r_ready(r_ready), .r_prod(r_prod),
  .hit_count(hit_count), .miss_count(miss_count), .q_full(q_full),
  .e_valid(e_valid), .e_pend(e_pend), .alloc(alloc), .v_idx(v_idx)
);

// File: tb/tb_prod_reuse_unit.sv
module tb_prod_reuse_unit;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int CW = 4;
  localparam int AW = 8;
  localparam int NE = 4;
  localparam int QD = 8;
  localparam int PW = CW + AW;

  logic          clk, rst_n, act_load, w_valid, w_ready, r_valid, r_ready;
  logic [AW-1:0] act_in;
  logic [CW-1:0] w_code;
  logic [PW-1:0] r_prod;
  logic [15:0]   hit_count, miss_count;

  prod_reuse_unit #(.CODE_W(CW), .ACT_W(AW), .ENTRIES(NE), .QDEPTH(QD),
                    .CNT_W(16), .STAMP_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .act_load(act_load), .act_in(act_in),
    .w_valid(w_valid), .w_ready(w_ready), .w_code(w_code), .r_valid(r_valid),
    .r_ready(r_ready), .r_prod(r_prod), .hit_count(hit_count),
    .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit          m_valid [NE];
  logic [CW-1:0] m_code [NE];
  int          m_freq [NE];
  int          m_stamp [NE];
  int          m_rdy [NE];
  int          m_use = 0;
  int          m_hit = 0;
  int          m_miss = 0;
  logic [AW-1:0] m_act = '0;
  int          edge_n = 0;
  int          acc_n = 0;
  bit          lat_on = 0;
  logic [PW-1:0] eq_prod [$];
  int          eq_edge [$];
  int          eq_lat [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_prod(input logic [CW-1:0] c, input logic [AW-1:0] a);
    logic signed [PW-1:0] ce, ae;
    ce = PW'(signed'(c));
    ae = PW'(signed'(a));
    return ce * ae;
  endfunction

  task automatic m_load(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) m_valid[i] = 0;
    m_use = 0;
    m_act = a;
  endtask

  task automatic m_accept(input logic [CW-1:0] c);
    int f, vic, lat;
    bit h;
    f = -1; vic = -1; lat = 0;
    for (int i = 0; i < NE; i++)
      if (f < 0 && m_valid[i] && m_code[i] == c) f = i;
    if (f >= 0) begin
      h = (edge_n >= m_rdy[f]);
      if (m_freq[f] < 15) m_freq[f]++;
      m_stamp[f] = m_use;
      if (h) begin m_hit++; lat = 1; end
      else m_miss++;
    end else begin
      m_miss++;
      for (int i = 0; i < NE; i++) if (vic < 0 && !m_valid[i]) vic = i;
      if (vic < 0) begin
        for (int i = 0; i < NE; i++) begin
          if (edge_n >= m_rdy[i]) begin
            if (vic < 0 || m_freq[i] < m_freq[vic] ||
                (m_freq[i] == m_freq[vic] && m_stamp[i] < m_stamp[vic])) vic = i;
          end
        end
      end
      m_valid[vic] = 1; m_code[vic] = c; m_freq[vic] = 1;
      m_stamp[vic] = m_use; m_rdy[vic] = edge_n + 4;
      lat = 4;
    end
    if (m_use < 65535) m_use++;
    if (eq_prod.size() != 0 || !lat_on) lat = 0;
    eq_prod.push_back(ref_prod(c, m_act));
    eq_edge.push_back(edge_n);
    eq_lat.push_back(lat);
  endtask

  task automatic step(input logic v, input logic [CW-1:0] c, input logic ld,
                      input logic [AW-1:0] a, input logic rdy);
    @(negedge clk);
    w_valid = v; w_code = c; act_load = ld; act_in = a; r_ready = rdy;
    #(HALF - 1);
    chk(hit_count == 16'(m_hit), "R8", "hit_count", hit_count, m_hit);
    chk(miss_count == 16'(m_miss), "R8", "miss_count", miss_count, m_miss);
    if (ld) chk(!w_ready, "R6", "w_ready during load", w_ready, 0);
    if (r_valid && r_ready) begin
      if (eq_prod.size() == 0) begin
        chk(0, "R2", "unexpected result", 1, 0);
      end else begin
        logic [PW-1:0] ep;
        int ee, el;
        ep = eq_prod.pop_front(); ee = eq_edge.pop_front(); el = eq_lat.pop_front();
        chk(r_prod == ep, "R1", "product", r_prod, ep);
        if (el == 1) chk(edge_n - ee == 1, "R3", "hit latency", edge_n - ee, 1);
        if (el == 4) chk(edge_n - ee == 4, "R4", "miss latency", edge_n - ee, 4);
      end
    end
    if (ld) m_load(a);
    if (v && w_ready) begin
      m_accept(c);
      acc_n++;
    end
    edge_n++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 1);
  endtask

  task automatic send(input logic [CW-1:0] c, input int gap);
    step(1, c, 0, '0, 1);
    idle(gap);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: finished=0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int h0, m0, a0;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; act_load = 0; act_in = '0; w_valid = 0; w_code = '0; r_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #(HALF - 1);
    // R10
    chk(!r_valid, "R10", "r_valid after reset", r_valid, 0);
    chk(w_ready, "R10", "w_ready after reset", w_ready, 1);
    chk(hit_count == 0 && miss_count == 0, "R10", "counters after reset",
        hit_count + miss_count, 0);

    lat_on = 1;
    // R4 then R3: isolated miss, later hit
    step(0, '0, 1, 8'd5, 1);
    send(4'd3, 6);
    h0 = hit_count;
    send(4'd3, 3);
    chk(hit_count == 16'(h0 + 1), "R3", "repeat code hit", hit_count, h0 + 1);

    // R5: back-to-back repeats join the in-flight multiply
    h0 = hit_count; m0 = miss_count;
    step(1, 4'd7, 0, '0, 1);
    step(1, 4'd7, 0, '0, 1);
    step(1, 4'd7, 0, '0, 1);
    step(1, 4'd7, 0, '0, 1);
    idle(6);
    chk(miss_count == 16'(m0 + 4), "R5", "joined misses", miss_count, m0 + 4);
    chk(hit_count == 16'(h0), "R5", "no hits while pending", hit_count, h0);
    send(4'd7, 3);
    chk(hit_count == 16'(h0 + 1), "R5", "hit once stored", hit_count, h0 + 1);

    // R6 and R1: negative operands after a load
    step(0, '0, 1, 8'hFD, 1);
    m0 = miss_count;
    send(4'd8, 6);
    chk(miss_count == 16'(m0 + 1), "R6", "miss after load", miss_count, m0 + 1);

    // R6: load while a multiply is in flight must not refill the cache
    step(1, 4'd2, 0, '0, 1);
    step(0, '0, 1, 8'd1, 1);
    idle(6);
    m0 = miss_count;
    send(4'd2, 6);
    chk(miss_count == 16'(m0 + 1), "R6", "killed fill not reused", miss_count, m0 + 1);

    // R7: eviction by use count then age
    step(0, '0, 1, 8'd1, 1);
    send(4'd1, 5); send(4'd2, 5); send(4'd3, 5); send(4'd4, 5);
    send(4'd1, 2); send(4'd1, 2); send(4'd2, 2);
    send(4'd5, 6);
    h0 = hit_count; m0 = miss_count;
    send(4'd4, 3);
    chk(hit_count == 16'(h0 + 1), "R7", "newer equal-count entry kept", hit_count, h0 + 1);
    send(4'd3, 6);
    chk(miss_count == 16'(m0 + 1), "R7", "older equal-count entry evicted", miss_count, m0 + 1);
    // R7 saturation: many matches on one code, then churn
    for (int i = 0; i < 20; i++) send(4'd1, 0);
    idle(4);
    send(4'd9, 5); send(4'd10, 5); send(4'd11, 5);
    h0 = hit_count;
    send(4'd1, 3);
    chk(hit_count == 16'(h0 + 1), "R7", "hot code retained", hit_count, h0 + 1);

    // R9: back-pressure fills the queue
    lat_on = 0;
    a0 = acc_n;
    for (int i = 0; i < 12; i++) step(1, 4'(i), 0, '0, 0);
    step(0, '0, 0, '0, 0);
    chk(!w_ready, "R9", "w_ready when full", w_ready, 0);
    chk(acc_n - a0 == QD, "R9", "accepted before stall", acc_n - a0, QD);
    chk(r_valid, "R9", "r_valid held", r_valid, 1);
    idle(12);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [CW-1:0] c;
      logic ld;
      ld = ($urandom % 150 == 0);
      c = ($urandom % 3 == 0) ? CW'($urandom % 16) : CW'($urandom % 5);
      step(!ld && ($urandom % 4 != 0), c, ld, 8'($urandom), $urandom % 4 != 0);
    end
    idle(20);
    // R2
    chk(eq_prod.size() == 0, "R2", "results outstanding", eq_prod.size(), 0);
    chk(!r_valid, "R2", "r_valid when drained", r_valid, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule